// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Interrupts

This block controls a 32-pin general-purpose I/O port through a plain word-wide register port: one address, a write strobe, write data and a combinational read-data bus. Software chooses each pin's direction and drives output values. It can do so either by writing the whole data word or by writing a mask to one of three write-only alias addresses that set, clear or invert only the selected bits. This lets two agents change different pins without a read-modify-write race.

Every pad input passes through a two-flop synchronizer. The synchronized level can be read back for every pin, including pins that are driving. The same level feeds a per-pin event detector. Each pin can trigger on low level, high level, rising edge or falling edge. A per-pin both-edges bit overrides that choice. Detected events latch into sticky status bits, which software clears by writing ones. A per-pin enable mask selects which status bits drive the single interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data, direction, both trigger words, mask and both-edges registers read 0, and pad_oe, pad_out and irq are 0.
- R2: The direction register (0x04) drives pad_oe bit for bit, with 1 meaning output. The data register (0x00) drives pad_out, and reading 0x00 returns the driven values.
- R3: A write to 0x84 sets, to 0x88 clears and to 0x8C inverts each data bit whose write-data bit is 1. Data bits written as 0 keep their value. All three addresses read as 0.
- R4: Address 0x08 returns the synchronized pad levels for every pin regardless of direction. Writes to it have no effect.
- R5: Each pin has a 2-bit trigger code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pins 0..15 use word 0x0C and pins 16..31 use word 0x10, with a pin's field at bits [2*(p mod 16)+1 : 2*(p mod 16)].
- R6: When a pin's bit in the both-edges register (0x1C) is 1, any change of its synchronized level triggers it, a steady level never does, and its trigger code is ignored.
- R7: Status (0x18) bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. A level trigger sets the bit again on every cycle the level lasts. An event in the same cycle as a clear leaves the bit set.
- R8: Status bits record events whatever the mask (0x14) holds.
- R9: irq is 1 exactly when some pin has both its status bit and its mask bit at 1.
- R10: A change on pad_in appears at 0x08 after two rising clock edges, and its event sets status on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output values to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps mixed per-pin trigger configurations over pairs of pad patterns. A design that read a trigger field from the wrong word or bit position, or let the trigger code leak through the both-edges override, would set the wrong status bits. It times a clear write so that it lands on the same edge as a fresh rising edge; a design that let the clear win would lose that event. It also clears a pin whose level trigger is still active and expects the bit to return at once. Finally, it walks a single mask bit across all 32 pins to catch a misrouted interrupt contribution, and it reads the pad status one edge early and on time to pin down the synchronizer depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_PAD    = 8'h08;
  localparam logic [7:0] OFF_CFG_LO = 8'h0C;
  localparam logic [7:0] OFF_CFG_HI = 8'h10;
  localparam logic [7:0] OFF_MASK   = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h18;
  localparam logic [7:0] OFF_BOTH   = 8'h1C;
  localparam logic [7:0] OFF_SET    = 8'h84;
  localparam logic [7:0] OFF_CLR    = 8'h88;
  localparam logic [7:0] OFF_TGL    = 8'h8C;

  localparam int unsigned PINS_PER_CFG = 16;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // lowest bit of a pin's trigger field inside its configuration word
  function automatic int unsigned field_lsb(int unsigned pin);
    return (pin % PINS_PER_CFG) * 2;
  endfunction

  // does the current/previous sample pair fire this pin
  function automatic logic trig_hit(trig_e code, logic both, logic cur, logic prev);
    logic res;
    if (both) begin
      res = cur ^ prev;
    end else begin
      case (code)
        TRIG_LOW:  res = ~cur;
        TRIG_HIGH: res = cur;
        TRIG_RISE: res = cur & ~prev;
        default:   res = ~cur & prev;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

  for (genvar s = 1; s < STAGES; s++) begin : g_chk
    // R10: every stage is exactly one edge behind the one before it
    p_sync_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stg_q[s] == $past(stg_q[s-1])));
  end

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   smp,
  input  logic [2*NPINS-1:0] codes,
  input  logic [NPINS-1:0]   both,
  output logic [NPINS-1:0]   evt
);

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign evt[p] = trig_hit(trig_e'(codes[2*p +: 2]), both[p], smp[p], prev_q[p]);

    // R6: a steady level never fires a both-edges pin
    p_both_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (both[p] && (smp[p] == prev_q[p])) |-> !evt[p]);
    // R6: any change fires a both-edges pin whatever its code
    p_both_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (both[p] && (smp[p] != prev_q[p])) |-> evt[p]);
  end

endmodule

// File: rtl/gpio_int_status.sv
module gpio_int_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] status,
  output logic             irq
);

  logic [NPINS-1:0] st_q;
  logic [NPINS-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_eff) | evt;
  end

  assign status = st_q;
  assign irq    = |(st_q & mask);

  // R7: only a written 1 can drop a status bit
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & ~$past(clr_eff)) & ~st_q) == '0));
  // R7, R8: an event always lands, even against a clear and with mask 0
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~st_q) == '0));
  // R9: nothing enabled means no interrupt
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  // R9: no pending status means no interrupt
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam int unsigned DW = 32;

  logic [NPINS-1:0] data_q, data_d, dir_q, mask_q, both_q;
  logic [DW-1:0]    cfg_lo_q, cfg_hi_q;
  logic [NPINS-1:0] pad_smp, evt, status;
  logic [2*NPINS-1:0] codes;

  // named write strobes
  logic wr_data, wr_dir, wr_cfg_lo, wr_cfg_hi, wr_mask, wr_stat, wr_both;
  logic wr_set, wr_clr, wr_tgl;
  assign wr_data   = wr_en && (addr == AW'(OFF_DATA));
  assign wr_dir    = wr_en && (addr == AW'(OFF_DIR));
  assign wr_cfg_lo = wr_en && (addr == AW'(OFF_CFG_LO));
  assign wr_cfg_hi = wr_en && (addr == AW'(OFF_CFG_HI));
  assign wr_mask   = wr_en && (addr == AW'(OFF_MASK));
  assign wr_stat   = wr_en && (addr == AW'(OFF_STAT));
  assign wr_both   = wr_en && (addr == AW'(OFF_BOTH));
  assign wr_set    = wr_en && (addr == AW'(OFF_SET));
  assign wr_clr    = wr_en && (addr == AW'(OFF_CLR));
  assign wr_tgl    = wr_en && (addr == AW'(OFF_TGL));

  always_comb begin
    data_d = data_q;
    if (wr_data)     data_d = wdata[NPINS-1:0];
    else if (wr_set) data_d = data_q | wdata[NPINS-1:0];
    else if (wr_clr) data_d = data_q & ~wdata[NPINS-1:0];
    else if (wr_tgl) data_d = data_q ^ wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else begin
      data_q <= data_d;
      if (wr_dir)    dir_q    <= wdata[NPINS-1:0];
      if (wr_cfg_lo) cfg_lo_q <= wdata;
      if (wr_cfg_hi) cfg_hi_q <= wdata;
      if (wr_mask)   mask_q   <= wdata[NPINS-1:0];
      if (wr_both)   both_q   <= wdata[NPINS-1:0];
    end
  end

  // gather each pin's trigger field from the word that holds it
  for (genvar p = 0; p < NPINS; p++) begin : g_code
    if (p < PINS_PER_CFG) begin : g_lo
      assign codes[2*p +: 2] = cfg_lo_q[field_lsb(p) +: 2];
    end else begin : g_hi
      assign codes[2*p +: 2] = cfg_hi_q[field_lsb(p) +: 2];
    end
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_smp)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .smp(pad_smp), .codes(codes),
    .both(both_q), .evt(evt)
  );

  gpio_int_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_we(wr_stat),
    .clr_mask(wdata[NPINS-1:0]), .mask(mask_q), .status(status), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFF_DATA):   rdata = DW'(data_q);
      AW'(OFF_DIR):    rdata = DW'(dir_q);
      AW'(OFF_PAD):    rdata = DW'(pad_smp);
      AW'(OFF_CFG_LO): rdata = cfg_lo_q;
      AW'(OFF_CFG_HI): rdata = cfg_hi_q;
      AW'(OFF_MASK):   rdata = DW'(mask_q);
      AW'(OFF_STAT):   rdata = DW'(status);
      AW'(OFF_BOTH):   rdata = DW'(both_q);
      default:         rdata = '0;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  // R3: set alias leaves every written bit high
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pad_out & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));
  // R3: clear alias leaves every written bit low
  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pad_out & $past(wdata[NPINS-1:0])) == '0));
  // R3: toggle alias inverts written bits and keeps the rest
  p_tgl_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgl |=> (pad_out == ($past(pad_out) ^ $past(wdata[NPINS-1:0]))));
  // R3: alias addresses read as zero
  p_alias_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr == AW'(OFF_SET)) || (addr == AW'(OFF_CLR)) || (addr == AW'(OFF_TGL)))
      |-> (rdata == '0));
  // R2: direction only moves on a direction write
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe));

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_PAD = 8'h08,
    A_CLO = 8'h0C, A_CHI = 8'h10, A_MASK = 8'h14, A_STAT = 8'h18,
    A_BOTH = 8'h1C, A_SET = 8'h84, A_CLR = 8'h88, A_TGL = 8'h8C;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of one pin's trigger decision
  function automatic bit exp_hit(int code, bit both, bit cur, bit prv);
    if (both) return cur != prv;
    if (code == 0) return !cur;
    if (code == 1) return cur;
    if (code == 2) return cur && !prv;
    return !cur && prv;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, model, s_pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // ---- R1 reset state
    rd(A_DATA, v); check("R1 data", v, 0);
    rd(A_DIR, v);  check("R1 dir", v, 0);
    rd(A_CLO, v);  check("R1 cfg lo", v, 0);
    rd(A_CHI, v);  check("R1 cfg hi", v, 0);
    rd(A_MASK, v); check("R1 mask", v, 0);
    rd(A_BOTH, v); check("R1 both", v, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 irq", {31'd0, irq}, 0);
    // code 0 is low level and pads are low: every pin fires, mask 0 hides it (R5, R8)
    rd(A_STAT, v); check("R5 low-level default", v, 32'hFFFF_FFFF);
    check("R8 masked irq", {31'd0, irq}, 0);

    // ---- R2 direction and data
    wr(A_DIR, 32'hFFFF_0000); check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    wr(A_DATA, 32'h1234_5678); check("R2 pad_out", pad_out, 32'h1234_5678);
    rd(A_DATA, v); check("R2 data read", v, 32'h1234_5678);

    // ---- R3 aliases
    model = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] m;
      m = 32'h0F1E_2D3C * (i + 3);
      case (i % 3)
        0: begin wr(A_SET, m); model = model | m;  end
        1: begin wr(A_CLR, m); model = model & ~m; end
        default: begin wr(A_TGL, m); model = model ^ m; end
      endcase
      rd(A_DATA, v); check("R3 alias update", v, model);
    end
    rd(A_SET, v); check("R3 set reads 0", v, 0);
    rd(A_CLR, v); check("R3 clear reads 0", v, 0);
    rd(A_TGL, v); check("R3 toggle reads 0", v, 0);

    // ---- R4 / R10 pad status and latency, pins configured as outputs
    wr(A_DIR, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'hC0DE_1234; addr = A_PAD;
    @(negedge clk); #1 check("R10 one edge still old", rdata, 32'h0000_0000);
    @(negedge clk); #1 check("R10 two edges new", rdata, 32'hC0DE_1234);
    check("R4 outputs keep data", pad_out, model);
    wr(A_PAD, 32'h5555_AAAA);
    rd(A_PAD, v); check("R4 pad write ignored", v, 32'hC0DE_1234);
    wr(A_DIR, 32'h0);

    // ---- R5 / R6 mixed configuration sweep
    for (int s = 0; s < 6; s++) begin
      logic [31:0] lo, hi, bm, pa, pb, e1, e2;
      lo = 0; hi = 0; bm = 0;
      for (int p = 0; p < 32; p++) begin
        int c;
        c = (p * 7 + s) % 4;
        if (p < 16) lo = lo | (32'(c) << (2 * p));
        else        hi = hi | (32'(c) << (2 * (p - 16)));
        if ((p + 2 * s) % 5 == 0) bm[p] = 1'b1;
      end
      pa = 32'h9E37_79B9 * (s + 1);
      pb = pa ^ {pa[15:0], pa[31:16]} ^ (32'h0F0F_00FF << s);
      e1 = 0; e2 = 0;
      for (int p = 0; p < 32; p++) begin
        int c;
        c = (p * 7 + s) % 4;
        e1[p] = exp_hit(c, bm[p], pa[p], pa[p]);
        e2[p] = e1[p] | exp_hit(c, bm[p], pb[p], pa[p]) | exp_hit(c, bm[p], pb[p], pb[p]);
      end
      wr(A_CLO, lo); wr(A_CHI, hi); wr(A_BOTH, bm);
      rd(A_CLO, v); check("R5 cfg lo readback", v, lo);
      rd(A_CHI, v); check("R5 cfg hi readback", v, hi);
      rd(A_BOTH, v); check("R6 both readback", v, bm);
      @(negedge clk); pad_in = pa;
      idle(5);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); check("R5 R6 steady level", v, e1);
      @(negedge clk); pad_in = pb;
      idle(4);
      rd(A_STAT, v); check("R5 R6 after transition", v, e2);
    end

    // ---- R7 clear semantics with rising-edge triggers
    wr(A_BOTH, 0); wr(A_CLO, 32'hAAAA_AAAA); wr(A_CHI, 32'hAAAA_AAAA);
    @(negedge clk); pad_in = 0;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R7 edge bits cleared", v, 0);
    s_pat = 32'hC3A5_5A3C;
    // edge reaches the status flop on the same edge as a clear-all write
    @(negedge clk); pad_in = s_pat;
    @(negedge clk);
    @(negedge clk); addr = A_STAT; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(A_STAT, v); check("R7 event beats clear", v, s_pat);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R7 zero write keeps", v, s_pat);

    // ---- R9 / R8 interrupt mask
    check("R8 status with mask 0, irq", {31'd0, irq}, 0);
    for (int p = 0; p < 32; p++) begin
      wr(A_MASK, 32'h1 << p);
      check($sformatf("R9 irq pin %0d", p), {31'd0, irq}, {31'd0, s_pat[p]});
    end
    wr(A_MASK, ~s_pat); check("R9 disjoint mask", {31'd0, irq}, 0);
    wr(A_MASK, 32'hFFFF_FFFF); check("R9 all enabled", {31'd0, irq}, 1);

    wr(A_STAT, 32'h0000_FFFF);
    rd(A_STAT, v); check("R7 partial clear", v, s_pat & 32'hFFFF_0000);

    // ---- R7 level trigger persists through a clear
    wr(A_CLO, 32'h5555_5555); wr(A_CHI, 32'h5555_5555);
    idle(2);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R7 level re-sets", v, s_pat);
    @(negedge clk); pad_in = 0;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R7 level gone clears", v, 0);
    check("R9 irq drops", {31'd0, irq}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule